// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Aligner

This block sits between the load/store stage of a 64-bit pipeline and a data memory that is 64 bits wide and addressed by byte. Each request carries an effective address, an access width (1, 2, 4 or 8 bytes), a load/store direction and, for loads, a zero-fill flag. The lowest address bits pick the byte lanes. The most significant byte of a multi-byte operand sits at the lowest address.

For a store, the block moves the low-order bytes of the source register onto the addressed lanes of the memory write bus and raises one write strobe per lane that is written. For a load, it takes the addressed bytes out of the memory read doubleword, which is valid in the same cycle as the request. It extends them to 64 bits and returns the result from a register one clock later. If an access is not naturally aligned, the block raises a fault in the request cycle and suppresses the access: no strobes are driven and no load result is produced.

Top module: `be_ldst_align`

## Requirements
- R1: The byte lane with offset k (k = address bits [2:0]) occupies data bits [63-8k : 56-8k] on both the read bus and the write bus, so the lowest-addressed byte of an operand is its most significant byte.
- R2: `req_size` encodes the width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. `align_fault` is high in the request cycle exactly when `req_valid` is high and the address is not a multiple of the width. It is low whenever `req_valid` is low.
- R3: On a faulting request, `mem_be` and `mem_wdata` are all zero in that cycle, and `load_valid` is low in the following cycle.
- R4: An aligned store drives `mem_be` with exactly 1, 2, 4 or 8 consecutive ones, starting at bit `mem_be[offset]`, where `mem_be[k]` strobes lane k. `mem_be` is zero when no store is requested.
- R5: An aligned store places the low 8, 16, 32 or 64 bits of `req_wdata` on the addressed lanes, with the most significant of those bytes on the lowest-offset lane. All other lanes of `mem_wdata` are zero, and the whole bus is zero when no store is requested.
- R6: A 1-byte load with `req_unsigned` high returns the byte with bits [63:8] zero. With `req_unsigned` low, bits [63:8] are copies of bit 7 of the byte.
- R7: A 2-byte load and a 4-byte load always sign-extend to 64 bits. `req_unsigned` has no effect on them.
- R8: An 8-byte load at offset 0 returns `mem_rdata` unchanged.
- R9: For an aligned load, `load_valid` is high in exactly the cycle after the request and `load_data` holds the result in that cycle. `load_valid` is low after every other cycle.
- R10: While `rst` is high at a clock edge, `load_valid` and `load_data` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Effective byte address |
| req_size | input | 2 | Access width code (R2) |
| req_unsigned | input | 1 | Zero-fill for 1-byte loads |
| req_wdata | input | DATA_W | Store source register value |
| mem_rdata | input | DATA_W | Memory read doubleword, valid with a load request |
| mem_wdata | output | DATA_W | Lane-placed store data |
| mem_be | output | DATA_W/8 | Per-lane write strobes |
| align_fault | output | 1 | Misalignment fault, request cycle |
| load_valid | output | 1 | Registered load result valid |
| load_data | output | DATA_W | Registered, extended load result |

## Verification
The bench builds the block with its default DATA_W of 64 and an ADDR_W of 32. This makes all eight lane offsets and all four widths reachable, so every aligned and misaligned offset/width combination can be exercised. The upper address bits carry random values, which checks that only the low three bits affect lane choice and alignment. Directed sweeps cover each offset for every width in both directions and both fill modes. Long random streams mix loads, stores, idle cycles and a mid-run reset against a byte-by-byte model.

// File: rtl/be_ldst_pkg.sv
package be_ldst_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE   = 2'd0,
    SZ_HALF   = 2'd1,
    SZ_WORD   = 2'd2,
    SZ_DOUBLE = 2'd3
  } acc_size_e;

endpackage

// File: rtl/be_lane_decode.sv
// Alignment test and lane mask for one access.
module be_lane_decode #(
  parameter int LANES = 8,
  parameter int OFS_W = 3
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [1:0]       size,
  output logic             misaligned,
  output logic [LANES-1:0] lane_mask
);
  localparam int SPAN_W = OFS_W + 1;

  logic [SPAN_W-1:0] span;
  logic [SPAN_W-1:0] ofs_ext;
  logic [SPAN_W-1:0] end_lane;

  always_comb begin
    span       = SPAN_W'(1) << size;
    ofs_ext    = {1'b0, offset};
    end_lane   = ofs_ext + span;
    misaligned = |(offset & OFS_W'(span - SPAN_W'(1)));
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_mask[k] = (ofs_ext <= SPAN_W'(k)) && (SPAN_W'(k) < end_lane);
  end

endmodule

// File: rtl/be_store_place.sv
// Places the low-order source bytes onto big-endian lanes.
module be_store_place #(
  parameter int DATA_W = 64,
  parameter int LANES  = 8,
  parameter int OFS_W  = 3
) (
  input  logic [OFS_W-1:0]  offset,
  input  logic [1:0]        size,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] placed
);
  localparam int SPAN_W = OFS_W + 1;

  logic [SPAN_W-1:0] last_lane;

  always_comb last_lane = {1'b0, offset} + (SPAN_W'(1) << size) - SPAN_W'(1);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SPAN_W-1:0] src_idx;
    logic [OFS_W-1:0]  src_sel;
    always_comb begin
      src_idx = last_lane - SPAN_W'(k);
      src_sel = src_idx[OFS_W-1:0];
      placed[DATA_W-1-8*k -: 8] = lane_mask[k] ? src[{src_sel, 3'b000} +: 8] : 8'h00;
    end
    logic unused_idx_hi;
    assign unused_idx_hi = src_idx[SPAN_W-1];
  end

endmodule

// File: rtl/be_load_extract.sv
// Picks addressed bytes from the read word, extends them, registers result.
module be_load_extract
  import be_ldst_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OFS_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OFS_W-1:0]  offset,
  input  logic [1:0]        size,
  input  logic              zero_fill,
  input  logic [DATA_W-1:0] rdata,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_data
);
  acc_size_e         sz;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] extended;

  always_comb begin
    sz      = acc_size_e'(size);
    shifted = rdata << {offset, 3'b000};
    case (sz)
      SZ_BYTE:
        extended = zero_fill ? {{(DATA_W-8){1'b0}}, shifted[DATA_W-1 -: 8]}
                             : {{(DATA_W-8){shifted[DATA_W-1]}}, shifted[DATA_W-1 -: 8]};
      SZ_HALF:   extended = {{(DATA_W-16){shifted[DATA_W-1]}}, shifted[DATA_W-1 -: 16]};
      SZ_WORD:   extended = {{(DATA_W-32){shifted[DATA_W-1]}}, shifted[DATA_W-1 -: 32]};
      default:   extended = shifted;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_valid <= 1'b0;
      load_data  <= '0;
    end else begin
      load_valid <= in_valid;
      if (in_valid) load_data <= extended;
    end
  end

  assert_valid_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> $past(in_valid));

  assert_zero_fill_byte_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sz == SZ_BYTE && zero_fill) |=> (load_data[DATA_W-1:8] == '0));

  assert_double_passthru_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sz == SZ_DOUBLE) |=> (load_data == $past(rdata)));

endmodule

// File: rtl/be_ldst_align.sv
module be_ldst_align
  import be_ldst_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_store,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [1:0]            req_size,
  input  logic                  req_unsigned,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W/8-1:0]   mem_be,
  output logic                  align_fault,
  output logic                  load_valid,
  output logic [DATA_W-1:0]     load_data
);
  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  logic [OFS_W-1:0]  offset;
  logic              misaligned;
  logic [LANES-1:0]  lane_mask;
  logic [DATA_W-1:0] placed;
  logic              store_ok;
  logic              load_ok;
  logic              unused_addr_hi;

  assign offset         = req_addr[OFS_W-1:0];
  assign unused_addr_hi = ^req_addr[ADDR_W-1:OFS_W];

  be_lane_decode #(.LANES(LANES), .OFS_W(OFS_W)) decode_i (
    .offset     (offset),
    .size       (req_size),
    .misaligned (misaligned),
    .lane_mask  (lane_mask)
  );

  be_store_place #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) place_i (
    .offset    (offset),
    .size      (req_size),
    .lane_mask (lane_mask),
    .src       (req_wdata),
    .placed    (placed)
  );

  always_comb begin
    align_fault = req_valid && misaligned;
    store_ok    = req_valid && req_store && !misaligned;
    load_ok     = req_valid && !req_store && !misaligned;
    mem_be      = store_ok ? lane_mask : '0;
    mem_wdata   = store_ok ? placed : '0;
  end

  be_load_extract #(.DATA_W(DATA_W), .OFS_W(OFS_W)) extract_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (load_ok),
    .offset     (offset),
    .size       (req_size),
    .zero_fill  (req_unsigned),
    .rdata      (mem_rdata),
    .load_valid (load_valid),
    .load_data  (load_data)
  );

  assert_fault_no_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (mem_be == '0 && mem_wdata == '0));

  assert_fault_no_result_R3: assert property (@(posedge clk) disable iff (rst)
    align_fault |=> !load_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!align_fault && mem_be == '0));

  assert_strobe_count_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_store && !align_fault) |-> ($countones(mem_be) == (1 << req_size)));

  assert_strobe_first_lane_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_store && !align_fault) |-> mem_be[offset]);

endmodule

// File: tb/be_ldst_align_tb_top.sv
`timescale 1ns/1ps
module be_ldst_align_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0, mem_rdata = '0;
  logic [63:0] mem_wdata, load_data;
  logic [7:0]  mem_be;
  logic        align_fault, load_valid;

  int nchecks = 0;
  int nerr    = 0;
  bit done    = 0;

  logic        exp_lv = 1'b0;
  logic [63:0] exp_ld = '0;
  string       exp_tag = "R9";

  always #2.5 clk = ~clk;

  be_ldst_align #(.DATA_W(64), .ADDR_W(32)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_size(req_size), .req_unsigned(req_unsigned),
    .req_wdata(req_wdata), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .align_fault(align_fault), .load_valid(load_valid),
    .load_data(load_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lane_of(input logic [63:0] d, input int k);
    return d[63-8*k -: 8];
  endfunction

  function automatic logic [63:0] model_load(input logic [63:0] rd, input int ofs,
                                             input int sz, input bit uns);
    logic [63:0] v = '0;
    int n = 1 << sz;
    for (int i = 0; i < n; i++) v = (v << 8) | 64'(lane_of(rd, ofs + i));
    case (sz)
      0: if (!uns && v[7])  v = v | 64'hFFFF_FFFF_FFFF_FF00;
      1: if (v[15])         v = v | 64'hFFFF_FFFF_FFFF_0000;
      2: if (v[31])         v = v | 64'hFFFF_FFFF_0000_0000;
      default: ;
    endcase
    return v;
  endfunction

  task automatic cyc(input bit v, input bit st, input logic [31:0] addr, input int sz,
                     input bit uns, input logic [63:0] wd, input logic [63:0] rd);
    int ofs, n;
    bit flt;
    logic [7:0]  ebe;
    logic [63:0] ewd, eld;
    string ltag;
    @(negedge clk);
    req_valid = v; req_store = st; req_addr = addr; req_size = 2'(sz);
    req_unsigned = uns; req_wdata = wd; mem_rdata = rd;
    #2;
    ofs = int'(addr[2:0]);
    n   = 1 << sz;
    flt = v && (ofs % n != 0);
    ebe = '0; ewd = '0;
    if (v && st && !flt)
      for (int i = 0; i < n; i++) begin
        ebe[ofs + i] = 1'b1;
        ewd[63-8*(ofs+i) -: 8] = wd[8*(n-1-i) +: 8];
      end
    chk("R2 fault", 64'(align_fault), 64'(flt));
    chk(flt ? "R3 strobes" : "R4 strobes", 64'(mem_be), 64'(ebe));
    chk(flt ? "R3 wdata" : "R5/R1 wdata", mem_wdata, ewd);
    chk("R9 load_valid", 64'(load_valid), 64'(exp_lv));
    if (exp_lv) chk(exp_tag, load_data, exp_ld);
    eld  = model_load(rd, ofs, sz, uns);
    ltag = (sz == 0) ? "R6/R1 byte load" : (sz == 3) ? "R8 double load" : "R7/R1 load";
    exp_lv  = v && !st && !flt;
    exp_ld  = eld;
    exp_tag = ltag;
  endtask

  task automatic idle();
    cyc(0, 0, 32'h0, 0, 0, 64'h0, 64'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    chk("R10 reset valid", 64'(load_valid), 64'h0);
    chk("R10 reset data", load_data, 64'h0);
    @(negedge clk);
    rst = 1'b0;
    exp_lv = 1'b0;
  endtask

  initial begin
    logic [63:0] rd1 = 64'h0123_4567_89AB_CDEF;
    logic [63:0] rd2 = 64'hF0E1_D2C3_B4A5_9687;
    logic [63:0] src = 64'h1122_3344_5566_7788;
    do_reset();
    // R6 byte loads at every lane, both fill modes
    for (int o = 0; o < 8; o++) begin
      cyc(1, 0, 32'h1000 + 32'(o), 0, 0, 64'h0, rd2);
      cyc(1, 0, 32'h1000 + 32'(o), 0, 1, 64'h0, rd2);
    end
    // R7 half/word loads, flag toggled, plus misaligned offsets (R2, R3)
    for (int o = 0; o < 8; o++) begin
      cyc(1, 0, 32'hABC0_0000 + 32'(o), 1, o[0], 64'h0, rd2);
      cyc(1, 0, 32'hABC0_0000 + 32'(o), 2, o[1], 64'h0, rd1);
      cyc(1, 0, 32'hABC0_0000 + 32'(o), 3, 0, 64'h0, rd1);
    end
    idle();
    // R4 R5 stores of every width at every offset
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 8; o++)
        cyc(1, 1, 32'h7FFF_FFF8 + 32'(o), s, 0, src, 64'h0);
    // misaligned load right after aligned load (R3 no result)
    cyc(1, 0, 32'h8, 3, 0, 64'h0, rd1);
    cyc(1, 0, 32'h9, 1, 0, 64'h0, rd1);
    idle();
    idle();
    // random stream
    for (int i = 0; i < 4000; i++) begin
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom,
          $urandom_range(0, 3), $urandom_range(0, 1) == 1,
          {$urandom, $urandom}, {$urandom, $urandom});
      if (i == 2000) do_reset();
    end
    idle();
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

endmodule